// File: doc/BRIEF.md
# Programmable Period Timer with External Gate, Reset and Start Modes

This block is an up-counting period timer. A prescaler divides the system clock by a power of two and produces a one-cycle tick enable. Each tick advances the count register. When the count reaches the programmed period, it returns to zero on the next tick, and the period match feeds a postscaler. The postscaler emits a single-cycle pulse after a programmable number of matches. Downstream logic uses the pulse as a periodic trigger, and software can read and write the count, the period and the configuration.

A 5-bit mode field sets how the timer reacts to an external input. The input can gate counting, clear the count on a rising edge or while it is high, or start a single run. In one-shot modes the timer switches itself off at the first period match. In monostable mode it only parks until the next external edge. The external input passes through a synchronizer. While the debug-freeze input is high, the sampled external level is held, so no external trigger is acted on.

Top module: `period_timer`

## Requirements
- R1: Each prescaler tick advances the count by one. The 3-bit select field s in configuration bits 7:5 gives one tick every 2^s running clock cycles. The first tick comes 2^s cycles after the prescaler is cleared.
- R2: A tick that finds the count equal to the period loads zero, so one period lasts period+1 ticks. A period of zero keeps the count at zero.
- R3: Each period match advances the postscaler. On the match that finds the postscaler equal to the 5-bit limit field (run-control bits 4:0), the postscaler clears and the pulse output goes high for one clock in the next cycle. A limit of L therefore gives one pulse per L+1 matches.
- R4: Reset makes the count 00h, the period FFh, both control words 00h and the pulse output low.
- R5: A count write loads the count and clears the prescaler and postscaler. A write to either control word clears the prescaler and postscaler and leaves the count unchanged.
- R6: The count holds while the on bit (run-control bit 7) is 0. Mode 0, and every mode value not listed in R7 to R10, counts whenever the on bit is 1 and ignores the external input.
- R7: Mode 8 counts as soon as the on bit is set. Mode 9 waits for a rising external edge after the on bit is set. In both modes the first period match clears the on bit and stops the count at zero. Writing the on bit to 1 again starts a new run.
- R8: Mode 16 waits for a rising external edge. The edge clears the count and starts a run. The run stops at the first period match with the on bit still 1, and a later rising edge starts it again.
- R9: In mode 1 the count advances only while the synchronized external level is high, and it holds its value while that level is low.
- R10: While the on bit is 1, mode 2 clears the count and both scalers on each rising external edge and ignores a steady level. Mode 3 holds them cleared for as long as the external level is high.
- R11: While freeze is high, the sampled external level keeps its last value. No edge, gate change or level reset takes effect until freeze falls.
- R12: Register addresses are 0 for the count, 1 for the period, 2 for run control and 3 for configuration. Reads return the stored values, and unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for the register at addr |
| ext_in | input | 1 | External gate, reset or start signal |
| freeze | input | 1 | Debug freeze: holds the sampled external level |
| pulse_out | output | 1 | Postscaled period-match pulse |

## Verification
The bench uses the default parameters: an 8-bit count, a 5-bit postscale limit, a 3-bit prescale select and a two-stage synchronizer. With these values a divide-by-128 run, periods of 0 and FFh, and a postscale limit of 2 all complete in a few hundred cycles. Every mode can be driven through a full start, match and stop, and the external-input latency of three flops can be counted exactly.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

  localparam int MODE_W = 5;

  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_RUN    = 2'd2;
  localparam logic [1:0] ADDR_CFG    = 2'd3;

  typedef enum logic [MODE_W-1:0] {
    MODE_FREE       = 5'd0,
    MODE_HW_GATE    = 5'd1,
    MODE_EDGE_CLR   = 5'd2,
    MODE_LEVEL_CLR  = 5'd3,
    MODE_SHOT_SW    = 5'd8,
    MODE_SHOT_EDGE  = 5'd9,
    MODE_MONO_EDGE  = 5'd16
  } mode_e;

  // Unlisted encodings fall back to free running.
  function automatic mode_e decode_mode(input logic [MODE_W-1:0] raw);
    case (raw)
      5'd1:    decode_mode = MODE_HW_GATE;
      5'd2:    decode_mode = MODE_EDGE_CLR;
      5'd3:    decode_mode = MODE_LEVEL_CLR;
      5'd8:    decode_mode = MODE_SHOT_SW;
      5'd9:    decode_mode = MODE_SHOT_EDGE;
      5'd16:   decode_mode = MODE_MONO_EDGE;
      default: decode_mode = MODE_FREE;
    endcase
  endfunction

endpackage

// File: rtl/ptm_ext_sync.sv
module ptm_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  input  logic freeze,
  output logic lvl,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              held_q, held_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], ext_in};
    held_d = freeze ? held_q : sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      held_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      held_q <= held_d;
      prev_q <= held_q;
    end
  end

  assign lvl  = held_q;
  assign rise = held_q & ~prev_q;

  // R11: a frozen cycle never lets the accepted level move
  assert_freeze_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(lvl));

endmodule

// File: rtl/ptm_prescaler.sv
module ptm_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] mask;

  // Low sel bits of the divider must all be one for a tick.
  for (genvar i = 0; i < DIV_W; i++) begin : g_mask
    assign mask[i] = (sel > SEL_W'(i));
  end

  assign tick = en & ((div_q & mask) == mask);

  always_comb begin
    div_d = div_q;
    if (clr)     div_d = '0;
    else if (en) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R1: after a clear no tick comes at once unless dividing by one
  assert_clear_delays_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!tick || sel == '0));

endmodule

// File: rtl/ptm_postscaler.sv
module ptm_postscaler #(
  parameter int PS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            match,
  input  logic [PS_W-1:0] limit,
  output logic            pulse
);

  logic [PS_W-1:0] pcnt_q, pcnt_d;
  logic            pulse_d;
  logic            hit;

  assign hit = match & (pcnt_q == limit);

  always_comb begin
    pcnt_d  = pcnt_q;
    pulse_d = 1'b0;
    if (clr) begin
      pcnt_d = '0;
    end else if (hit) begin
      pcnt_d  = '0;
      pulse_d = 1'b1;
    end else if (match) begin
      pcnt_d = pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      pulse  <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      pulse  <= pulse_d;
    end
  end

  // R3: the match counter never passes the limit
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= limit);

  // R3: with a nonzero limit the pulse is a single cycle
  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && limit != '0) |=> !pulse);

endmodule

// File: rtl/period_timer.sv
module period_timer
  import ptm_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PS_W        = 5,
  parameter int PRE_SEL_W   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic             ext_in,
  input  logic             freeze,
  output logic             pulse_out
);

  localparam int ON_BIT = CNT_W - 1;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // Registers
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [CNT_W-1:0]     per_q, per_d;
  logic                 on_q, on_d;
  logic [PS_W-1:0]      lim_q, lim_d;
  logic [PRE_SEL_W-1:0] sel_q, sel_d;
  logic [MODE_W-1:0]    mraw_q, mraw_d;
  logic                 started_q, started_d;

  logic wr_cnt, wr_per, wr_run, wr_cfg, wr_ctl;
  assign wr_cnt = wr_en && (addr == ADDR_COUNT);
  assign wr_per = wr_en && (addr == ADDR_PERIOD);
  assign wr_run = wr_en && (addr == ADDR_RUN);
  assign wr_cfg = wr_en && (addr == ADDR_CFG);
  assign wr_ctl = wr_run | wr_cfg;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  // External input conditioning
  logic ext_lvl, ext_rise;

  ptm_ext_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ext_in (ext_in),
    .freeze (freeze),
    .lvl    (ext_lvl),
    .rise   (ext_rise)
  );

  // Mode decode into gate, clear and start terms
  mode_e mode;
  logic  gate_ok, clr_raw, start_raw, needs_start, self_stop;

  assign mode = decode_mode(mraw_q);

  always_comb begin
    gate_ok     = 1'b1;
    clr_raw     = 1'b0;
    start_raw   = 1'b0;
    needs_start = 1'b0;
    self_stop   = 1'b0;
    case (mode)
      MODE_HW_GATE:   gate_ok = ext_lvl;
      MODE_EDGE_CLR:  clr_raw = ext_rise;
      MODE_LEVEL_CLR: clr_raw = ext_lvl;
      MODE_SHOT_SW:   self_stop = 1'b1;
      MODE_SHOT_EDGE: begin
        self_stop   = 1'b1;
        needs_start = 1'b1;
        start_raw   = ext_rise;
      end
      MODE_MONO_EDGE: begin
        needs_start = 1'b1;
        start_raw   = ext_rise;
        clr_raw     = ext_rise;
      end
      default: ;
    endcase
  end

  logic ext_clr, start_evt, run, tick, at_period, match_evt, scal_clr;

  assign ext_clr   = clr_raw & on_q;
  assign start_evt = start_raw & on_q;
  assign run       = on_q & gate_ok & (~needs_start | started_q);
  assign at_period = (cnt_q == per_q);
  assign match_evt = tick & at_period & ~wr_cnt & ~ext_clr;
  assign scal_clr  = wr_cnt | wr_ctl | ext_clr;

  ptm_prescaler #(.SEL_W(PRE_SEL_W)) i_pre (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (scal_clr),
    .en    (run),
    .sel   (sel_q),
    .tick  (tick)
  );

  ptm_postscaler #(.PS_W(PS_W)) i_post (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (scal_clr),
    .match (match_evt),
    .limit (lim_q),
    .pulse (pulse_out)
  );

  // Next state
  always_comb begin
    cnt_d = cnt_q;
    if (wr_cnt)       cnt_d = wdata;
    else if (ext_clr) cnt_d = '0;
    else if (tick)    cnt_d = at_period ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    per_d  = wr_per ? wdata : per_q;
    lim_d  = wr_run ? wdata[PS_W-1:0] : lim_q;
    sel_d  = wr_cfg ? wdata[MODE_W +: PRE_SEL_W] : sel_q;
    mraw_d = wr_cfg ? wdata[MODE_W-1:0] : mraw_q;
  end

  always_comb begin
    on_d = on_q;
    if (wr_run)                      on_d = wdata[ON_BIT];
    else if (match_evt && self_stop) on_d = 1'b0;
  end

  always_comb begin
    started_d = started_q;
    if (!on_q || wr_ctl)                started_d = 1'b0;
    else if (start_evt)                 started_d = 1'b1;
    else if (match_evt && needs_start)  started_d = 1'b0;
  end

  // Register stage
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cnt_q     <= '0;
      per_q     <= '1;
      on_q      <= 1'b0;
      lim_q     <= '0;
      sel_q     <= '0;
      mraw_q    <= '0;
      started_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      per_q     <= per_d;
      on_q      <= on_d;
      lim_q     <= lim_d;
      sel_q     <= sel_d;
      mraw_q    <= mraw_d;
      started_q <= started_d;
    end
  end

  // Read mux
  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_COUNT:  rdata = cnt_q;
      ADDR_PERIOD: rdata = per_q;
      ADDR_RUN: begin
        rdata[ON_BIT]      = on_q;
        rdata[PS_W-1:0]    = lim_q;
      end
      default: begin
        rdata[MODE_W +: PRE_SEL_W] = sel_q;
        rdata[MODE_W-1:0]          = mraw_q;
      end
    endcase
  end

  // R2: a tick at the period value lands on zero
  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (match_evt) |=> (cnt_q == '0));

  // R6: a stopped timer keeps its count
  assert_off_holds_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!on_q && !wr_cnt) |=> $stable(cnt_q));

  // R7: one-shot match switches the timer off
  assert_shot_clears_on_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (self_stop && match_evt && !wr_run) |=> !on_q);

  // R8: monostable match parks the timer with on still set
  assert_mono_parks_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == MODE_MONO_EDGE && match_evt && !wr_ctl) |=> (on_q && !run));

  // R9: closed gate freezes the count
  assert_gate_hold_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == MODE_HW_GATE && !ext_lvl && !wr_cnt) |=> $stable(cnt_q));

  // R10: a high level in level-clear mode forces zero
  assert_level_clear_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == MODE_LEVEL_CLR && on_q && ext_lvl && !wr_cnt) |=> (cnt_q == '0));

endmodule

// File: tb/test_period_timer.sv
module test_period_timer;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       ext_in;
  logic       freeze;
  logic       pulse_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  period_timer i_period_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .ext_in    (ext_in),
    .freeze    (freeze),
    .pulse_out (pulse_out)
  );

  // {period[34:27], select[26:24], cycles[23:8], expected count[7:0]}
  localparam logic [34:0] VECS [NVEC] = '{
    {8'd255, 3'd0, 16'd10,  8'd10},
    {8'd9,   3'd0, 16'd25,  8'd5},
    {8'd255, 3'd3, 16'd70,  8'd8},
    {8'd4,   3'd1, 16'd23,  8'd1},
    {8'd0,   3'd0, 16'd5,   8'd0},
    {8'd255, 3'd7, 16'd300, 8'd2},
    {8'd100, 3'd2, 16'd50,  8'd12}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    check(req, int'(rdata), int'(exp));
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Stop, configure, clear count, start
  task automatic setup(input logic [7:0] per, input logic [7:0] cfg,
                       input logic [7:0] cnt, input logic [7:0] run);
    wr(2'd2, 8'h00);
    wr(2'd1, per);
    wr(2'd3, cfg);
    wr(2'd0, cnt);
    wr(2'd2, run);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
    ext_in = 1'b0; freeze = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);

    // R4 reset state, R12 register map
    expect_reg("R4", 2'd0, 8'h00);
    expect_reg("R4", 2'd1, 8'hFF);
    expect_reg("R4", 2'd2, 8'h00);
    expect_reg("R12", 2'd3, 8'h00);
    check("R4", int'(pulse_out), 0);

    // R1/R2 vector table: count = (cycles >> select) mod (period+1)
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h80);
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd1, VECS[i][34:27]);
      wr(2'd3, {VECS[i][26:24], 5'd0});
      wr(2'd0, 8'h00);
      cycles(int'(VECS[i][23:8]));
      expect_reg("R1_R2", 2'd0, VECS[i][7:0]);
    end
    expect_reg("R12", 2'd3, {3'd2, 5'd0});

    // R3 postscaler: period 3, limit 2 -> pulse every 12 cycles
    begin
      int npulse = 0;
      int first = 0;
      setup(8'd3, 8'h00, 8'h00, 8'h82);
      wr(2'd0, 8'h00);
      for (int j = 1; j <= 48; j++) begin
        @(negedge clk);
        if (pulse_out) begin
          npulse++;
          if (first == 0) first = j;
        end
      end
      check("R3", first, 12);
      check("R3", npulse, 4);
    end

    // R5 count write / control write, R6 on bit
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h80);
    wr(2'd0, 8'h40);
    cycles(5);
    expect_reg("R5", 2'd0, 8'h45);
    wr(2'd2, 8'h00);
    expect_reg("R5", 2'd0, 8'h46);
    cycles(10);
    expect_reg("R6", 2'd0, 8'h46);
    wr(2'd2, 8'h80);
    expect_reg("R5", 2'd0, 8'h46);
    cycles(3);
    expect_reg("R6", 2'd0, 8'h49);

    // R7 mode 8 one-shot
    setup(8'd5, 8'd8, 8'h00, 8'h80);
    cycles(3);
    expect_reg("R7", 2'd0, 8'h03);
    cycles(10);
    expect_reg("R7", 2'd0, 8'h00);
    expect_reg("R7", 2'd2, 8'h00);
    cycles(10);
    expect_reg("R7", 2'd0, 8'h00);
    wr(2'd2, 8'h80);
    cycles(2);
    expect_reg("R7", 2'd0, 8'h02);
    cycles(20);

    // R7 mode 9 edge-started one-shot
    setup(8'd5, 8'd9, 8'h00, 8'h80);
    cycles(10);
    expect_reg("R7", 2'd0, 8'h00);
    ext_in = 1'b1;
    cycles(7);
    expect_reg("R7", 2'd0, 8'h03);
    cycles(20);
    expect_reg("R7", 2'd0, 8'h00);
    expect_reg("R7", 2'd2, 8'h00);
    ext_in = 1'b0;
    cycles(5);

    // R8 mode 16 monostable
    setup(8'd5, 8'd16, 8'h00, 8'h80);
    cycles(10);
    expect_reg("R8", 2'd0, 8'h00);
    ext_in = 1'b1;
    cycles(7);
    expect_reg("R8", 2'd0, 8'h03);
    cycles(20);
    expect_reg("R8", 2'd0, 8'h00);
    expect_reg("R8", 2'd2, 8'h80);
    ext_in = 1'b0;
    cycles(5);
    ext_in = 1'b1;
    cycles(7);
    expect_reg("R8", 2'd0, 8'h03);
    cycles(20);
    ext_in = 1'b0;
    cycles(5);

    // R9 mode 1 hardware gate
    setup(8'hFF, 8'd1, 8'h10, 8'h80);
    cycles(5);
    expect_reg("R9", 2'd0, 8'h10);
    ext_in = 1'b1;
    cycles(10);
    expect_reg("R9", 2'd0, 8'h17);
    ext_in = 1'b0;
    cycles(10);
    expect_reg("R9", 2'd0, 8'h1A);
    cycles(5);
    expect_reg("R9", 2'd0, 8'h1A);

    // R10 mode 2 rising-edge clear
    setup(8'hFF, 8'd2, 8'h50, 8'h80);
    cycles(5);
    expect_reg("R10", 2'd0, 8'h55);
    ext_in = 1'b1;
    cycles(10);
    expect_reg("R10", 2'd0, 8'h06);
    cycles(10);
    expect_reg("R10", 2'd0, 8'h10);
    ext_in = 1'b0;
    cycles(5);

    // R10 mode 3 level clear
    setup(8'hFF, 8'd3, 8'h20, 8'h80);
    cycles(4);
    expect_reg("R10", 2'd0, 8'h24);
    ext_in = 1'b1;
    cycles(10);
    expect_reg("R10", 2'd0, 8'h00);
    cycles(5);
    expect_reg("R10", 2'd0, 8'h00);
    ext_in = 1'b0;
    cycles(10);
    expect_reg("R10", 2'd0, 8'h07);

    // R11 freeze blocks the level clear until released
    freeze = 1'b1;
    ext_in = 1'b1;
    cycles(10);
    expect_reg("R11", 2'd0, 8'h11);
    freeze = 1'b0;
    cycles(10);
    expect_reg("R11", 2'd0, 8'h00);
    ext_in = 1'b0;
    cycles(10);

    // R6 unlisted mode 5 ignores the external input
    setup(8'hFF, 8'd5, 8'h00, 8'h80);
    ext_in = 1'b1;
    cycles(12);
    expect_reg("R6", 2'd0, 8'h0C);
    ext_in = 1'b0;

    // R4 reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    cycles(4);
    expect_reg("R4", 2'd0, 8'h00);
    expect_reg("R4", 2'd1, 8'hFF);
    expect_reg("R4", 2'd3, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule